// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Interrupt Flags

This block is a shared word memory for two processors, called port A and port B, used to pass messages between them. Both ports have their own synchronous read/write interface and can reach every word of the array. A read returns its data on the clock after the access. The lowest words of the array double as doorbells. Section A covers words 0 to 15 and section B covers words 16 to 31. Every word above that range is plain message storage with no side effects.

Each side owns a 16-bit flag register. Port A rings port B by writing any value into word i of section A. This sets bit i of flag register A. Port B acknowledges by reading that word, which clears the bit. Section B works the same way with the roles swapped. Each flag register has a mask register. The receiving port reaches that mask through a register window selected by a dedicated input, so port B masks flag register A and port A masks flag register B. The masked flags are ORed into one registered interrupt line per receiving port.

Top module: `mbox_dpram`

## Requirements
- R1: Either port can write any word and read it back. The read data appears on that port's rdata one clock after the read is sampled. A plain read returns the word as it was before any write in the same cycle.
- R2: Word i of section A (address i, 0 ≤ i ≤ 15) maps to bit i of flag register A. Word i of section B (address 16+i) maps to bit i of flag register B.
- R3: When port A writes any data to a section A word, the matching bit of flag register A is 1 on the next clock. The same rule applies to port B writing section B and flag register B.
- R4: When port B reads a section A word, the matching bit of flag register A clears. The same rule applies to port A reading section B and flag register B.
- R5: A write by the non-owning port into a section, or a read by the owning port from its own section, leaves that flag register unchanged. The data of such a write is still stored.
- R6: If a bit is set and cleared in the same cycle, the bit ends up set.
- R7: irq_to_b is the registered OR of (flag A AND mask A), and irq_to_a is the same for flag B and mask B. Each follows a flag or mask change one clock later. A mask bit of 0 blocks its flag bit from the interrupt.
- R8: After reset, both flag registers and both masks are zero and both interrupt outputs are low.
- R9: With rsel=1, a port reaches its mask register and the address is ignored. For port A this is mask B; for port B it is mask A. A write stores wdata. A read returns the value held before that cycle, one clock later. Masks change only through these writes.
- R10: If both ports write the same word in one cycle, port A's data is stored.
- R11: Accesses to words 32 and above and to the register window never change a flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_rsel | input | 1 | Port A targets its mask register instead of the array |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one clock after the read |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_rsel | input | 1 | Port B targets its mask register instead of the array |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one clock after the read |
| irq_to_a | output | 1 | Masked flag B interrupt for port A |
| irq_to_b | output | 1 | Masked flag A interrupt for port B |

## Verification
Accesses are driven on the falling edge and sampled by the next rising edge. Read data and flag updates therefore become visible at the falling edge that follows, and the bench checks rdata there. Interrupt outputs have one more register behind the flags and masks. The bench checks them only after one further idle cycle, comparing against a model built from R2 to R7. Mapping is confirmed bit by bit by sweeping one-hot masks, and each mask step is followed by that extra cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned SIDES = 2;
   localparam int unsigned SIDE_A = 0;
   localparam int unsigned SIDE_B = 1;

   typedef struct packed {
      logic en;
      logic we;
      logic rsel;
   } acc_ctl_t;

   function automatic int unsigned peer(input int unsigned s);
      return (s == SIDE_A) ? SIDE_B : SIDE_A;
   endfunction
endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          a_en,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_q,
   input  logic          b_en,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_q
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Port B is written first so that port A overrides it on a shared address.
   always_ff @(posedge clk) begin
      if (b_en && b_we) mem[b_addr] <= b_wdata;
      if (a_en && a_we) mem[a_addr] <= a_wdata;
   end

   always_ff @(posedge clk) begin
      if (a_en && !a_we) a_q <= mem[a_addr];
      if (b_en && !b_we) b_q <= mem[b_addr];
   end
endmodule

// File: rtl/mbox_sdec.sv
module mbox_sdec
   import mbox_pkg::*;
#(
   parameter int unsigned AW  = 12,
   parameter int unsigned NCH = 16
) (
   input  acc_ctl_t                 ctl,
   input  logic [AW-1:0]            addr,
   output logic [SIDES-1:0][NCH-1:0] wr_hit,
   output logic [SIDES-1:0][NCH-1:0] rd_hit
);
   localparam int unsigned CW   = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned SPAN = SIDES * NCH;

   logic          in_status;
   logic          sec;
   logic [CW-1:0] idx;
   logic [NCH-1:0] onehot;

   assign in_status = ctl.en && !ctl.rsel && (addr < AW'(SPAN));
   assign idx       = addr[CW-1:0];
   assign onehot    = NCH'(1) << idx;

   generate
      if (NCH > 1) begin : g_sec_wide
         assign sec = addr[CW];
      end else begin : g_sec_narrow
         assign sec = addr[0];
      end
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         assign wr_hit[s] = (in_status && ctl.we && (sec == 1'(s))) ? onehot : '0;
         assign rd_hit[s] = (in_status && !ctl.we && (sec == 1'(s))) ? onehot : '0;
      end
   endgenerate
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
   parameter int unsigned NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_v,
   input  logic [NCH-1:0] clr_v,
   input  logic           mask_we,
   input  logic [NCH-1:0] mask_wd,
   output logic [NCH-1:0] flags_q,
   output logic [NCH-1:0] mask_q,
   output logic           irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         mask_q  <= '0;
         irq     <= 1'b0;
      end else begin
         // set has priority over clear so a doorbell is never lost
         flags_q <= (flags_q & ~clr_v) | set_v;
         if (mask_we) mask_q <= mask_wd;
         irq <= |(flags_q & mask_q);
      end
   end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_pkg::*;
#(
   parameter int unsigned AW  = 12,
   parameter int unsigned DW  = 16,
   parameter int unsigned NCH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic          a_we,
   input  logic          a_rsel,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic          b_en,
   input  logic          b_we,
   input  logic          b_rsel,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata,
   output logic          irq_to_a,
   output logic          irq_to_b
);
   generate
      if ((NCH == 0) || ((NCH & (NCH - 1)) != 0)) begin : g_bad_nch
         $error("mbox_dpram: NCH must be a nonzero power of two");
      end
      if ((SIDES * NCH) > (1 << AW)) begin : g_bad_aw
         $error("mbox_dpram: status area does not fit the address space");
      end
      if (DW < NCH) begin : g_bad_dw
         $error("mbox_dpram: DW must hold a full mask");
      end
   endgenerate

   acc_ctl_t                           ctl   [SIDES];
   logic [AW-1:0]                      addr  [SIDES];
   logic [DW-1:0]                      wdata [SIDES];
   logic [DW-1:0]                      ram_q [SIDES];
   logic [SIDES-1:0][SIDES-1:0][NCH-1:0] wr_hit;
   logic [SIDES-1:0][SIDES-1:0][NCH-1:0] rd_hit;
   logic [SIDES-1:0][NCH-1:0]          mbox_q;
   logic [SIDES-1:0][NCH-1:0]          mask_q;
   logic [SIDES-1:0]                   irq_v;
   logic [SIDES-1:0]                   rsel_q;
   logic [NCH-1:0]                     mrd_q [SIDES];
   logic [DW-1:0]                      rdata [SIDES];

   assign ctl[SIDE_A]   = '{en: a_en, we: a_we, rsel: a_rsel};
   assign ctl[SIDE_B]   = '{en: b_en, we: b_we, rsel: b_rsel};
   assign addr[SIDE_A]  = a_addr;
   assign addr[SIDE_B]  = b_addr;
   assign wdata[SIDE_A] = a_wdata;
   assign wdata[SIDE_B] = b_wdata;

   mbox_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk     (clk),
      .a_en    (a_en && !a_rsel),
      .a_we    (a_we),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .a_q     (ram_q[SIDE_A]),
      .b_en    (b_en && !b_rsel),
      .b_we    (b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_q     (ram_q[SIDE_B])
   );

   generate
      for (genvar p = 0; p < SIDES; p++) begin : g_port
         mbox_sdec #(.AW(AW), .NCH(NCH)) u_sdec (
            .ctl    (ctl[p]),
            .addr   (addr[p]),
            .wr_hit (wr_hit[p]),
            .rd_hit (rd_hit[p])
         );

         // read-side register window: port p sees the mask of the peer's flags
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsel_q[p] <= 1'b0;
               mrd_q[p]  <= '0;
            end else if (ctl[p].en && !ctl[p].we) begin
               rsel_q[p] <= ctl[p].rsel;
               if (ctl[p].rsel) mrd_q[p] <= mask_q[peer(p)];
            end
         end

         assign rdata[p] = rsel_q[p] ? DW'(mrd_q[p]) : ram_q[p];
      end

      for (genvar s = 0; s < SIDES; s++) begin : g_mbox
         localparam int unsigned RX = (s == 0) ? 1 : 0;
         mbox_flags #(.NCH(NCH)) u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_v   (wr_hit[s][s]),
            .clr_v   (rd_hit[RX][s]),
            .mask_we (ctl[RX].en && ctl[RX].we && ctl[RX].rsel),
            .mask_wd (wdata[RX][NCH-1:0]),
            .flags_q (mbox_q[s]),
            .mask_q  (mask_q[s]),
            .irq     (irq_v[s])
         );
      end
   endgenerate

   assign a_rdata  = rdata[SIDE_A];
   assign b_rdata  = rdata[SIDE_B];
   assign irq_to_b = irq_v[SIDE_A];
   assign irq_to_a = irq_v[SIDE_B];
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
   parameter int unsigned AW  = 12,
   parameter int unsigned NCH = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                a_en,
   input logic                a_we,
   input logic                a_rsel,
   input logic [AW-1:0]       a_addr,
   input logic                b_en,
   input logic                b_we,
   input logic                b_rsel,
   input logic [AW-1:0]       b_addr,
   input logic [1:0][NCH-1:0] mbox,
   input logic [1:0][NCH-1:0] mask,
   input logic                irq_to_a,
   input logic                irq_to_b
);
   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

   logic a_stat, b_stat, a_wr_sa, b_wr_sb, b_rd_sa;
   assign a_stat  = a_en && !a_rsel && (a_addr < AW'(2 * NCH));
   assign b_stat  = b_en && !b_rsel && (b_addr < AW'(2 * NCH));
   assign a_wr_sa = a_en && a_we && !a_rsel && (a_addr < AW'(NCH));
   assign b_wr_sb = b_en && b_we && !b_rsel && (b_addr >= AW'(NCH)) && (b_addr < AW'(2 * NCH));
   assign b_rd_sa = b_en && !b_we && !b_rsel && (b_addr < AW'(NCH));

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mbox == '0) && (mask == '0) && !irq_to_a && !irq_to_b); // R8
   AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
      a_wr_sa |=> mbox[0][$past(a_addr[CW-1:0])]); // R3
   AST_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
      b_wr_sb |=> mbox[1][$past(b_addr[CW-1:0])]); // R3
   AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd_sa && !(a_wr_sa && (a_addr == b_addr))) |=> !mbox[0][$past(b_addr[CW-1:0])]); // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd_sa && a_wr_sa && (a_addr == b_addr)) |=> mbox[0][$past(b_addr[CW-1:0])]); // R6
   AST_MASK_BLOCKS_B: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[0] == '0) |=> !irq_to_b); // R7
   AST_MASK_BLOCKS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[1] == '0) |=> !irq_to_a); // R7
   AST_MASK_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_en && b_we && b_rsel) |=> $stable(mask[0])); // R9
   AST_MASK_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && a_we && a_rsel) |=> $stable(mask[1])); // R9
   AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_stat || b_stat) |=> $stable(mbox)); // R11
endmodule

bind mbox_dpram mbox_dpram_chk #(.AW(AW), .NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a_en     (a_en),
   .a_we     (a_we),
   .a_rsel   (a_rsel),
   .a_addr   (a_addr),
   .b_en     (b_en),
   .b_we     (b_we),
   .b_rsel   (b_rsel),
   .b_addr   (b_addr),
   .mbox     (mbox_q),
   .mask     (mask_q),
   .irq_to_a (irq_to_a),
   .irq_to_b (irq_to_b)
);

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int NCH = 16;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_en = 0, a_we = 0, a_rsel = 0;
   logic b_en = 0, b_we = 0, b_rsel = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic irq_to_a, irq_to_b;

   int checks = 0;
   int failures = 0;

   logic [DW-1:0]  mem_m [DEPTH];
   logic [NCH-1:0] mb_m [2];
   logic [NCH-1:0] mk_m [2];

   always #4 clk = ~clk;

   mbox_dpram #(.AW(AW), .DW(DW), .NCH(NCH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_rsel(a_rsel), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_en(b_en), .b_we(b_we), .b_rsel(b_rsel), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .irq_to_a(irq_to_a), .irq_to_b(irq_to_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access cycle on both ports, with model update per the requirements
   task automatic op(input string tag,
                     input logic ae, input logic awe, input logic ars, input int aad, input int awd,
                     input logic be, input logic bwe, input logic brs, input int bad, input int bwd);
      logic [DW-1:0] exp_a, exp_b;
      logic [NCH-1:0] set_v [2];
      logic [NCH-1:0] clr_v [2];
      a_en = ae; a_we = awe; a_rsel = ars; a_addr = AW'(aad); a_wdata = DW'(awd);
      b_en = be; b_we = bwe; b_rsel = brs; b_addr = AW'(bad); b_wdata = DW'(bwd);
      exp_a = ars ? DW'(mk_m[1]) : mem_m[aad];
      exp_b = brs ? DW'(mk_m[0]) : mem_m[bad];
      for (int s = 0; s < 2; s++) begin
         set_v[s] = '0;
         clr_v[s] = '0;
      end
      if (ae && !ars && aad < NCH) begin
         if (awe) set_v[0][aad] = 1'b1;
      end
      if (ae && !ars && aad >= NCH && aad < 2 * NCH) begin
         if (!awe) clr_v[1][aad - NCH] = 1'b1;
      end
      if (be && !brs && bad >= NCH && bad < 2 * NCH) begin
         if (bwe) set_v[1][bad - NCH] = 1'b1;
      end
      if (be && !brs && bad < NCH) begin
         if (!bwe) clr_v[0][bad] = 1'b1;
      end
      @(negedge clk);
      a_en = 0; b_en = 0;
      if (ae && !awe) chk({tag, " port A read"}, 32'(a_rdata), 32'(exp_a));
      if (be && !bwe) chk({tag, " port B read"}, 32'(b_rdata), 32'(exp_b));
      if (be && bwe && !brs) mem_m[bad] = DW'(bwd);
      if (ae && awe && !ars) mem_m[aad] = DW'(awd);
      if (ae && awe && ars) mk_m[1] = NCH'(awd);
      if (be && bwe && brs) mk_m[0] = NCH'(bwd);
      for (int s = 0; s < 2; s++) mb_m[s] = (mb_m[s] & ~clr_v[s]) | set_v[s];
   endtask

   task automatic opa(input string tag, input logic we, input logic rs, input int ad, input int wd);
      op(tag, 1'b1, we, rs, ad, wd, 1'b0, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic opb(input string tag, input logic we, input logic rs, input int ad, input int wd);
      op(tag, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, we, rs, ad, wd);
   endtask

   // one idle cycle lets the interrupt register catch up, then compare
   task automatic settle(input string tag);
      @(negedge clk);
      chk({tag, " irq_to_a"}, 32'(irq_to_a), 32'(|(mb_m[1] & mk_m[1])));
      chk({tag, " irq_to_b"}, 32'(irq_to_b), 32'(|(mb_m[0] & mk_m[0])));
   endtask

   task automatic mask_sweep(input string tag);
      logic [NCH-1:0] keep_a, keep_b;
      keep_a = mk_m[0];
      keep_b = mk_m[1];
      for (int j = 0; j < NCH; j++) begin
         op(tag, 1'b1, 1'b1, 1'b1, 0, 1 << j, 1'b1, 1'b1, 1'b1, 0, 1 << j);
         settle(tag);
      end
      op(tag, 1'b1, 1'b1, 1'b1, 0, int'(keep_b), 1'b1, 1'b1, 1'b1, 0, int'(keep_a));
      settle(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 'x;
      for (int s = 0; s < 2; s++) begin
         mb_m[s] = '0;
         mk_m[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      chk("R8 irq_to_a after reset", 32'(irq_to_a), 0);
      chk("R8 irq_to_b after reset", 32'(irq_to_b), 0);
      opa("R8 mask B reset", 1'b0, 1'b1, 0, 0);
      opb("R8 mask A reset", 1'b0, 1'b1, 0, 0);

      // R9: mask window, address ignored, old value on read-with-write
      opa("R9 write mask B", 1'b1, 1'b1, 77, 16'hFFFF);
      opb("R9 write mask A", 1'b1, 1'b1, 5, 16'hFFFF);
      op("R9 readback masks", 1'b1, 1'b0, 1'b1, 9, 0, 1'b1, 1'b0, 1'b1, 123, 0);
      settle("R8");

      // R1 and R11: message space sweep
      for (int k = 2 * NCH; k < DEPTH; k++) opa("R1 fill", 1'b1, 1'b0, k, (k * 37) ^ 16'h5A5A);
      for (int k = 2 * NCH; k < DEPTH; k++) opb("R1 sweep", 1'b0, 1'b0, k, 0);
      for (int k = 2 * NCH; k < DEPTH; k += 7) opb("R1 fill B", 1'b1, 1'b0, k, k ^ 16'hC3C3);
      for (int k = 2 * NCH; k < DEPTH; k += 7) opa("R1 sweep A", 1'b0, 1'b0, k, 0);
      settle("R11");

      // R3, R4, R5: per-channel doorbell life cycle for both sections
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < NCH; i++) begin
            int w;
            w = s * NCH + i;
            op("R3 owner write", s == 0, 1'b1, 1'b0, w, 16'h1000 + w,
               s == 1, 1'b1, 1'b0, w, 16'h2000 + w);
            settle("R3");
            op("R5 owner read", s == 0, 1'b0, 1'b0, w, 0, s == 1, 1'b0, 1'b0, w, 0);
            settle("R5");
            op("R4 peer read", s == 1, 1'b0, 1'b0, w, 0, s == 0, 1'b0, 1'b0, w, 0);
            settle("R4");
            op("R5 peer write", s == 1, 1'b1, 1'b0, w, 16'h3000 + w,
               s == 0, 1'b1, 1'b0, w, 16'h4000 + w);
            settle("R5");
            op("R5 data kept", 1'b1, 1'b0, 1'b0, w, 0, 1'b0, 1'b0, 1'b0, 0, 0);
         end
      end

      // R2: bit mapping by one-hot mask sweep
      opa("R2 ring A0", 1'b1, 1'b0, 0, 1);
      opa("R2 ring A3", 1'b1, 1'b0, 3, 2);
      opa("R2 ring A15", 1'b1, 1'b0, 15, 3);
      opb("R2 ring B6", 1'b1, 1'b0, NCH + 6, 4);
      opb("R2 ring B9", 1'b1, 1'b0, NCH + 9, 5);
      mask_sweep("R2");

      // R7: mask zero blocks, reopening raises one cycle later
      opb("R7 close mask A", 1'b1, 1'b1, 0, 0);
      opa("R7 close mask B", 1'b1, 1'b1, 0, 0);
      settle("R7 masked");
      opb("R7 open mask A bit3", 1'b1, 1'b1, 0, 16'h0008);
      settle("R7 reopen");
      opa("R7 open mask B bit9", 1'b1, 1'b1, 0, 16'h0200);
      settle("R7 reopen");

      // clear everything, then R6: same-cycle set and clear of A word 5
      for (int i = 0; i < NCH; i++) op("R4 drain", 1'b1, 1'b0, 1'b0, NCH + i, 0, 1'b1, 1'b0, 1'b0, i, 0);
      opb("R6 mask A", 1'b1, 1'b1, 0, 16'hFFFF);
      settle("R4 drained");
      op("R6 set vs clear", 1'b1, 1'b1, 1'b0, 5, 16'hBEEF, 1'b1, 1'b0, 1'b0, 5, 0);
      settle("R6");
      op("R6 set vs clear B", 1'b1, 1'b0, 1'b0, NCH + 2, 0, 1'b1, 1'b1, 1'b0, NCH + 2, 16'hCAFE);
      settle("R6");

      // R10: same-address writes and read-before-write
      op("R10 dual write", 1'b1, 1'b1, 1'b0, 100, 16'hAAAA, 1'b1, 1'b1, 1'b0, 100, 16'h5555);
      opb("R10 winner", 1'b0, 1'b0, 100, 0);
      op("R10 write vs read", 1'b1, 1'b1, 1'b0, 200, 16'h1234, 1'b1, 1'b0, 1'b0, 200, 0);
      op("R10 read vs write", 1'b1, 1'b0, 1'b0, 200, 0, 1'b1, 1'b1, 1'b0, 200, 16'h7777);
      opa("R10 final", 1'b0, 1'b0, 200, 0);
      settle("R10");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule